// File: doc/BRIEF.md
# Serial Transmitter with Sixteen-Entry Queue

This block turns characters written by a host into asynchronous serial frames on a single output line. Each write puts one character of up to nine bits into a first-in first-out queue. A frame engine takes characters from the head of the queue and sends each one as a low start bit, the payload bits least significant first, and a high stop period. Bit timing comes from an oversample tick supplied from outside the block, at sixteen ticks per bit. The baud generator and the receiver are outside this block.

The payload shape comes from a three-bit frame-format field, with an optional parity bit of odd or even sense. The stop period can be half a bit, one bit, one and a half bits or two bits long. A flow-control gate can hold back new frames while the clear-to-send input is low. Three status flags support refill: line idle and queue empty, queue at least half empty, and queue full. A flush strobe drops every queued character.

The frame engine is a four-state machine. IDLE holds the line high. The IDLE to START transition happens when the queue holds a character and the gate allows a start; in that cycle the head character is taken and the format is latched. START drives the line low for one bit time and then moves to DATA. DATA shifts out one payload bit per bit time, and after the last bit moves to STOP. STOP drives the line high for the selected stop length and then returns to IDLE.

Top module: `serial_tx_fifo`

## Requirements
- R1: After reset the line is high, `st_empty` and `st_half_empty` are 1, and `st_full` is 0.
- R2: A frame is a low start bit lasting 16 ticks, then payload bits least significant first at 16 ticks each, then a high stop period.
- R3: Frame-format codes that set the payload: 3'b001 sends data[7:0] (8 bits); 3'b100 sends data[8:0] (9 bits); 3'b101 sends data[7:0] followed by wake-up bit data[8] (9 bits); any code not listed in R3 or R4 sends 8 bits.
- R4: Code 3'b011 sends data[6:0] and then a parity bit (8 bits). Code 3'b111 sends data[7:0] and then a parity bit (9 bits). With `parity_odd`=0 the parity bit makes the number of ones, parity included, even. With `parity_odd`=1 that number is odd.
- R5: Stop-length codes: 2'b00 gives 8 ticks, 2'b01 gives 16, 2'b10 gives 24, 2'b11 gives 32.
- R6: The queue holds 16 characters and sends them in the order they were written.
- R7: `st_half_empty` is 1 while 8 or fewer characters are queued. `st_full` is 1 while 16 are queued.
- R8: A write while the queue is full is dropped and leaves the stored characters unchanged.
- R9: A flush pulse empties the queue, and a write in the same cycle is dropped. A frame already on the line finishes.
- R10: With `cts_gate_en`=1 and `cts_in`=0 no new frame starts. With `cts_gate_en`=0, `cts_in` has no effect.
- R11: `st_empty` is 1 only when the queue is empty and the frame engine is in IDLE.
- R12: Outside IDLE the frame engine moves only on cycles where `os_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversample tick, 16 per bit time |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 9 | Character to queue |
| tx_flush | input | 1 | Flush strobe that empties the queue |
| frame_mode | input | 3 | Frame-format code |
| stop_sel | input | 2 | Stop-length code |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| cts_gate_en | input | 1 | Enables gating of new frames on `cts_in` |
| cts_in | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial line, idles high |
| st_empty | output | 1 | Queue empty and line idle |
| st_half_empty | output | 1 | 8 or fewer characters queued |
| st_full | output | 1 | 16 characters queued |

## Verification
If the queue pointers or occupancy count go wrong, the status flags are off at the next cycle after a write. Characters also come out missing, repeated or reordered within one frame time of the fault. A fault in the frame engine's tick counter or bit counter shows on the line as a start bit, data bit or stop period of the wrong length, seen at the next bit boundary. A missed return to IDLE shows as `st_empty` never rising. The sampling points are bit centres, and the stop period is timed from the end of the last data bit to the rise of `st_empty`, so a fault that is off by one bit time or more is seen.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // Frame engine states
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    // Frame-format codes
    localparam logic [2:0] FMT_D8    = 3'b001;
    localparam logic [2:0] FMT_D7_P  = 3'b011;
    localparam logic [2:0] FMT_D9    = 3'b100;
    localparam logic [2:0] FMT_D8_WK = 3'b101;
    localparam logic [2:0] FMT_D8_P  = 3'b111;

    localparam int CHAR_W  = 9;
    localparam int FRAME_W = 10;
    localparam int NBITS_W = 4;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NBITS_W-1:0] nbits;
    } frame_t;

    // Build the payload and its bit count from a character and the format.
    function automatic frame_t pack_frame(input logic [2:0] fmt,
                                          input logic [CHAR_W-1:0] d,
                                          input logic odd);
        frame_t f;
        f.bits  = {2'b00, d[7:0]};
        f.nbits = NBITS_W'(8);
        case (fmt)
            FMT_D7_P: begin
                f.bits  = {3'b000, (^d[6:0]) ^ odd, d[6:0]};
                f.nbits = NBITS_W'(8);
            end
            FMT_D9, FMT_D8_WK: begin
                f.bits  = {1'b0, d};
                f.nbits = NBITS_W'(9);
            end
            FMT_D8_P: begin
                f.bits  = {1'b0, (^d[7:0]) ^ odd, d[7:0]};
                f.nbits = NBITS_W'(9);
            end
            default: begin
                f.bits  = {2'b00, d[7:0]};
                f.nbits = NBITS_W'(8);
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/tx_char_queue.sv
module tx_char_queue #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [LW-1:0]    cnt;
    logic             do_push, do_pop;

    assign do_push = push && !flush && (cnt != LW'(DEPTH));
    assign do_pop  = pop  && !flush && (cnt != '0);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + LW'(1);
                2'b01:   cnt <= cnt - LW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = store[rd_ptr];
    assign level = cnt;

    // R6: occupancy never exceeds the depth
    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LW'(DEPTH));

    // R8: a write into a full queue with no read leaves it full
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LW'(DEPTH) && push && !pop && !flush) |=> (cnt == LW'(DEPTH) && $stable(wr_ptr)));

    // R9: a flush empties the queue
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));

endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
    import uart_tx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              have_char,
    input  logic [CHAR_W-1:0] head_char,
    input  logic [2:0]        frame_mode,
    input  logic [1:0]        stop_sel,
    input  logic              parity_odd,
    input  logic              cts_gate_en,
    input  logic              cts_in,
    output logic              take,
    output logic              txd,
    output logic              busy
);
    localparam int HALF = OSR / 2;
    localparam int CW   = $clog2(2 * OSR + 1);

    tx_state_e          state_q, state_d;
    logic [FRAME_W-1:0] shift_q, shift_d;
    logic [NBITS_W-1:0] left_q,  left_d;
    logic [CW-1:0]      tick_q,  tick_d;
    logic [CW-1:0]      stop_q,  stop_d;
    logic               start_ok;
    frame_t             next_frame;

    assign start_ok   = have_char && (!cts_gate_en || cts_in);
    assign next_frame = pack_frame(frame_mode, head_char, parity_odd);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        shift_d = shift_q;
        left_d  = left_q;
        tick_d  = tick_q;
        stop_d  = stop_q;
        unique case (state_q)
            TX_IDLE: begin
                if (start_ok) begin
                    state_d = TX_START;
                    shift_d = next_frame.bits;
                    left_d  = next_frame.nbits;
                    stop_d  = CW'((32'(stop_sel) + 32'd1) * HALF);
                    tick_d  = '0;
                end
            end
            TX_START: begin
                if (os_tick) begin
                    if (tick_q == CW'(OSR - 1)) begin
                        tick_d  = '0;
                        state_d = TX_DATA;
                    end else begin
                        tick_d = tick_q + CW'(1);
                    end
                end
            end
            TX_DATA: begin
                if (os_tick) begin
                    if (tick_q == CW'(OSR - 1)) begin
                        tick_d  = '0;
                        shift_d = shift_q >> 1;
                        left_d  = left_q - NBITS_W'(1);
                        if (left_q == NBITS_W'(1)) state_d = TX_STOP;
                    end else begin
                        tick_d = tick_q + CW'(1);
                    end
                end
            end
            TX_STOP: begin
                if (os_tick) begin
                    if (tick_q == stop_q - CW'(1)) begin
                        tick_d  = '0;
                        state_d = TX_IDLE;
                    end else begin
                        tick_d = tick_q + CW'(1);
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            shift_q <= '0;
            left_q  <= '0;
            tick_q  <= '0;
            stop_q  <= CW'(OSR);
        end else begin
            state_q <= state_d;
            shift_q <= shift_d;
            left_q  <= left_d;
            tick_q  <= tick_d;
            stop_q  <= stop_d;
        end
    end

    // Outputs
    always_comb begin
        take = 1'b0;
        txd  = 1'b1;
        busy = 1'b1;
        unique case (state_q)
            TX_IDLE: begin
                busy = 1'b0;
                take = start_ok;
            end
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shift_q[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end

    // R10: a held-off gate keeps the engine in IDLE
    p_cts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && cts_gate_en && !cts_in) |=> (state_q == TX_IDLE));

    // R12: with no tick the line does not move mid-frame
    p_tick_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TX_IDLE && !os_tick) |=> $stable(txd));

    // R2: a frame begins with the line low
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && start_ok) |=> !txd);

endmodule

// File: rtl/serial_tx_fifo.sv
module serial_tx_fifo
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OSR   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              tx_flush,
    input  logic [2:0]        frame_mode,
    input  logic [1:0]        stop_sel,
    input  logic              parity_odd,
    input  logic              cts_gate_en,
    input  logic              cts_in,
    output logic              txd,
    output logic              st_empty,
    output logic              st_half_empty,
    output logic              st_full
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0]     level;
    logic [CHAR_W-1:0] head;
    logic              take, busy;

    tx_char_queue #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) i_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (take),
        .dout  (head),
        .level (level)
    );

    tx_frame_engine #(.OSR(OSR)) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .have_char   (level != '0),
        .head_char   (head),
        .frame_mode  (frame_mode),
        .stop_sel    (stop_sel),
        .parity_odd  (parity_odd),
        .cts_gate_en (cts_gate_en),
        .cts_in      (cts_in),
        .take        (take),
        .txd         (txd),
        .busy        (busy)
    );

    assign st_empty      = (level == '0) && !busy;
    assign st_half_empty = level <= LW'(DEPTH / 2);
    assign st_full       = level == LW'(DEPTH);

    // R11: with everything idle the line rests high
    p_empty_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_empty |-> txd);

    // R7: a full queue is never reported as half empty
    p_full_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |-> !st_half_empty);

endmodule

// File: tb/test_serial_tx_fifo.sv
`timescale 1ns/1ps
module test_serial_tx_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_flush = 1'b0;
    logic [2:0] frame_mode = 3'b001;
    logic [1:0] stop_sel = 2'b01;
    logic       parity_odd = 1'b0;
    logic       cts_gate_en = 1'b0;
    logic       cts_in = 1'b1;
    logic       txd, st_empty, st_half_empty, st_full;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    serial_tx_fifo i_serial_tx_fifo (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en), .wr_data(wr_data),
        .tx_flush(tx_flush), .frame_mode(frame_mode), .stop_sel(stop_sel),
        .parity_odd(parity_odd), .cts_gate_en(cts_gate_en), .cts_in(cts_in),
        .txd(txd), .st_empty(st_empty), .st_half_empty(st_half_empty), .st_full(st_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_nbits(input logic [2:0] m);
        if (m == 3'b100 || m == 3'b101 || m == 3'b111) return 9;
        return 8;
    endfunction

    function automatic logic [9:0] exp_frame(input logic [2:0] m, input logic [8:0] d,
                                             input logic odd);
        logic [9:0] r = '0;
        int ones = 0;
        int n = (m == 3'b011) ? 7 : (m == 3'b100 || m == 3'b101) ? 9 : 8;
        for (int i = 0; i < n; i++) begin
            r[i] = d[i];
            if (d[i]) ones++;
        end
        if (m == 3'b011 || m == 3'b111) r[n] = ((ones % 2) == 1) ^ odd;
        return r;
    endfunction

    // Receive one frame; called at a negedge, returns at a negedge.
    task automatic rx_frame(input int nb, input bit meas,
                            output logic [9:0] got, output int scnt);
        int w = 0;
        got = '0;
        scnt = 0;
        while (txd !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
        chk(w < 20000, "R2", "start bit seen", w, 0);
        repeat (8) @(negedge clk);
        chk(txd === 1'b0, "R2", "start bit centre low", int'(txd), 0);
        chk(st_empty === 1'b0, "R11", "not empty while sending", int'(st_empty), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (16) @(negedge clk);
            got[i] = txd;
        end
        repeat (8) @(negedge clk);
        if (meas) begin
            while (!st_empty && scnt < 200) begin
                if (txd !== 1'b1) chk(1'b0, "R2", "stop high", int'(txd), 1);
                scnt++;
                @(negedge clk);
            end
        end else begin
            chk(txd === 1'b1, "R2", "stop bit high", int'(txd), 1);
        end
    endtask

    task automatic put(input logic [8:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(st_empty === 1'b1, "R1", "empty after reset", int'(st_empty), 1);
        chk(st_half_empty === 1'b1, "R1", "half after reset", int'(st_half_empty), 1);
        chk(st_full === 1'b0, "R1", "full after reset", int'(st_full), 0);
    endtask

    task automatic t_one(input logic [2:0] m, input logic [8:0] d, input logic odd,
                         input logic [1:0] ss, input string req);
        logic [9:0] got;
        logic [9:0] exp;
        int sc;
        frame_mode = m;
        parity_odd = odd;
        stop_sel = ss;
        put(d);
        rx_frame(exp_nbits(m), 1'b1, got, sc);
        exp = exp_frame(m, d, odd);
        chk(got == exp, req, "payload", int'(got), int'(exp));
        chk(sc == (int'(ss) + 1) * 8, "R5", "stop ticks", sc, (int'(ss) + 1) * 8);
    endtask

    task automatic t_formats;
        t_one(3'b001, 9'h1A5, 1'b0, 2'b01, "R3");
        t_one(3'b100, 9'h13C, 1'b0, 2'b01, "R3");
        t_one(3'b101, 9'h155, 1'b0, 2'b01, "R3");
        t_one(3'b000, 9'h1C3, 1'b0, 2'b01, "R3");
        t_one(3'b111, 9'h00B, 1'b0, 2'b01, "R4");
        t_one(3'b111, 9'h00B, 1'b1, 2'b01, "R4");
        t_one(3'b011, 9'h0FF, 1'b0, 2'b01, "R4");
        t_one(3'b011, 9'h052, 1'b1, 2'b01, "R4");
    endtask

    task automatic t_stops;
        for (int s = 0; s < 4; s++) t_one(3'b001, 9'(8'h5A + s), 1'b0, 2'(s), "R5");
    endtask

    task automatic t_fill;
        logic [9:0] got;
        int sc;
        cts_gate_en = 1'b1;
        cts_in = 1'b0;
        frame_mode = 3'b100;
        stop_sel = 2'b00;
        for (int i = 0; i < 16; i++) begin
            put(9'(i * 7 + 3));
            if (i == 7) chk(st_half_empty === 1'b1, "R7", "half at 8", int'(st_half_empty), 1);
            if (i == 8) chk(st_half_empty === 1'b0, "R7", "half at 9", int'(st_half_empty), 0);
            if (i == 14) chk(st_full === 1'b0, "R7", "full at 15", int'(st_full), 0);
        end
        chk(st_full === 1'b1, "R7", "full at 16", int'(st_full), 1);
        put(9'h0AA);
        chk(st_full === 1'b1, "R8", "still full", int'(st_full), 1);
        chk(st_empty === 1'b0 && txd === 1'b1, "R10", "held by gate", int'(txd), 1);
        cts_in = 1'b1;
        for (int i = 0; i < 16; i++) begin
            rx_frame(9, i == 15, got, sc);
            chk(got == 10'(i * 7 + 3), "R6", "order", int'(got), i * 7 + 3);
        end
        chk(st_empty === 1'b1, "R8", "dropped write not sent", int'(st_empty), 1);
        cts_gate_en = 1'b0;
    endtask

    task automatic t_flush;
        int hi = 0;
        cts_gate_en = 1'b1;
        cts_in = 1'b0;
        for (int i = 0; i < 5; i++) put(9'(i + 1));
        chk(st_empty === 1'b0, "R9", "queued before flush", int'(st_empty), 0);
        tx_flush = 1'b1;
        wr_en = 1'b1;
        wr_data = 9'h077;
        @(negedge clk);
        tx_flush = 1'b0;
        wr_en = 1'b0;
        chk(st_empty === 1'b1, "R9", "empty after flush", int'(st_empty), 1);
        chk(st_half_empty === 1'b1 && st_full === 1'b0, "R9", "flags after flush",
            int'({st_half_empty, st_full}), 2);
        cts_in = 1'b1;
        for (int i = 0; i < 300; i++) begin
            if (txd === 1'b1) hi++;
            @(negedge clk);
        end
        chk(hi == 300, "R9", "nothing sent after flush", hi, 300);
    endtask

    task automatic t_cts;
        logic [9:0] got;
        int sc;
        int hi = 0;
        frame_mode = 3'b001;
        stop_sel = 2'b01;
        cts_gate_en = 1'b1;
        cts_in = 1'b0;
        put(9'h03C);
        for (int i = 0; i < 100; i++) begin
            if (txd === 1'b1) hi++;
            @(negedge clk);
        end
        chk(hi == 100, "R10", "no start while gated", hi, 100);
        chk(st_empty === 1'b0, "R11", "queued char not empty", int'(st_empty), 0);
        cts_in = 1'b1;
        rx_frame(8, 1'b1, got, sc);
        chk(got == 10'h03C, "R10", "sent after release", int'(got), 'h3C);
        cts_gate_en = 1'b0;
        cts_in = 1'b0;
        put(9'h0C5);
        rx_frame(8, 1'b1, got, sc);
        chk(got == 10'h0C5, "R10", "gate off ignores cts", int'(got), 'hC5);
        cts_in = 1'b1;
    endtask

    task automatic t_tick;
        int w = 0;
        int lo = 0;
        frame_mode = 3'b001;
        put(9'h00F);
        while (txd !== 1'b0 && w < 1000) begin @(negedge clk); w++; end
        os_tick = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd === 1'b0) lo++;
        end
        chk(lo == 100 && st_empty === 1'b0, "R12", "frozen without tick", lo, 100);
        os_tick = 1'b1;
        w = 0;
        while (st_empty !== 1'b1 && w < 1000) begin @(negedge clk); w++; end
        chk(st_empty === 1'b1, "R12", "completes after tick resumes", int'(st_empty), 1);
    endtask

    initial begin
        #(150000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_formats();
        t_stops();
        t_fill();
        t_flush();
        t_cts();
        t_tick();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule